// File: doc/BRIEF.md
# PS/2 Wake and Isolation Controller

This block sits on the four PS/2 lines (keyboard clock and data, mouse clock and data) between the board connectors and an on-chip keyboard controller. Two register bits let software cut either device off from the controller. A cut-off line reaches the controller at its idle high level. A separate register bit holds the controller in reset for as long as software leaves it set.

Wake detection works in parallel with the isolation path and always looks at the raw data lines. A data line that is low after synchronization sets a sticky status bit for that device. The active-low event output asserts whenever a status bit and its enable bit are both set.

The isolation, enable and status registers survive the main-domain power-on reset and clear only on the standby-domain power-on reset. The controller-reset register clears on either reset. Software uses a plain write/read port to reach all four registers.

Top module: `ps2_wake_iso`

## Requirements
- R1: Bit 6 of the isolation register (address 1) forces the mouse clock and data outputs to the controller high while set. While the bit is clear, both outputs follow the raw mouse inputs.
- R2: Bit 5 of the isolation register forces the keyboard clock and data outputs to the controller high while set. While the bit is clear, both outputs follow the raw keyboard inputs.
- R3: The standby reset clears the isolation, enable (address 2) and status (address 3) registers. The main reset leaves all three unchanged.
- R4: Bit 6 of the controller-reset register (address 0) drives `kbc_rst` high while set. It stays set until software writes it to 0 (0x40 asserts, 0x00 releases). Either reset clears it.
- R5: A low keyboard data line sets status bit 3, and a low mouse data line sets status bit 4. A line driven low before a clock edge shows in the status on the third rising edge after that.
- R6: Status detection ignores the isolation bits.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: If a set and a write-1 clear hit the same status bit in the same cycle, the set wins.
- R9: `pme_n` is low exactly when keyboard status (bit 3) and keyboard enable (bit 3) are both set, or when mouse status (bit 4) and mouse enable (bit 4) are both set.
- R10: Reads return the current register value at every address, and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| stby_rst_n | input | 1 | Standby-domain power-on reset, active low |
| main_rst_n | input | 1 | Main-domain power-on reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| kb_clk_i | input | 1 | Raw keyboard clock line |
| kb_dat_i | input | 1 | Raw keyboard data line |
| ms_clk_i | input | 1 | Raw mouse clock line |
| ms_dat_i | input | 1 | Raw mouse data line |
| kbc_kb_clk | output | 1 | Keyboard clock to the controller |
| kbc_kb_dat | output | 1 | Keyboard data to the controller |
| kbc_ms_clk | output | 1 | Mouse clock to the controller |
| kbc_ms_dat | output | 1 | Mouse data to the controller |
| kbc_rst | output | 1 | Held reset to the controller, active high |
| pme_n | output | 1 | Power management event, active low |

## Verification
The directed part of the bench covers several cases:
- It holds a data line low while that device is isolated, which separates the raw wake path from the gated controller path.
- It writes a clear while the line is still low, which shows whether set or clear wins.
- It writes zeros to a set status bit, which shows whether a 0 write disturbs it.
- It pulses the main reset with every register loaded, which tells the standby-domain registers apart from the controller-reset register.

The random part then mixes writes at any address, data lines that fall now and then, toggling clocks and rare resets of either domain. All of this is compared each cycle against a bench model of the registers and the two-flop delay.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;
   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_ADDR_W = 2;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // build a one-hot mask of a given width
   function automatic logic [31:0] bit_mask(input int unsigned pos);
      logic [31:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/ps2w_sync.sv
module ps2w_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ps2w_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= {WIDTH{RST_VAL}};
         end else begin
            if (s == 0) stage_q[s] <= d_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps2w_gate.sv
module ps2w_gate #(
   parameter logic BLOCK_LEVEL = 1'b1
) (
   input  logic clk_i,
   input  logic dat_i,
   input  logic block_i,
   output logic clk_o,
   output logic dat_o
);
   if (BLOCK_LEVEL) begin : g_block_high
      assign clk_o = clk_i | block_i;
      assign dat_o = dat_i | block_i;
   end else begin : g_block_low
      assign clk_o = clk_i & ~block_i;
      assign dat_o = dat_i & ~block_i;
   end
endmodule

// File: rtl/ps2w_regs.sv
module ps2w_regs
   import ps2w_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned A_CTL     = 0,
   parameter int unsigned A_ISO     = 1,
   parameter int unsigned A_EN      = 2,
   parameter int unsigned A_STS     = 3,
   parameter int unsigned B_CTL_RST = 6,
   parameter int unsigned B_ISO_MS  = 6,
   parameter int unsigned B_ISO_KB  = 5,
   parameter int unsigned B_KB      = 3,
   parameter int unsigned B_MS      = 4
) (
   input  logic              clk,
   input  logic              stby_rst_n,
   input  logic              main_rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              kb_act_i,
   input  logic              ms_act_i,
   output logic [DATA_W-1:0] iso_o,
   output logic [DATA_W-1:0] en_o,
   output logic [DATA_W-1:0] sts_o,
   output logic              ctl_rst_o
);
   localparam logic [DATA_W-1:0] CTL_MASK  = DATA_W'(bit_mask(B_CTL_RST));
   localparam logic [DATA_W-1:0] ISO_MASK  = DATA_W'(bit_mask(B_ISO_MS) | bit_mask(B_ISO_KB));
   localparam logic [DATA_W-1:0] WAKE_MASK = DATA_W'(bit_mask(B_KB) | bit_mask(B_MS));

   logic [DATA_W-1:0] ctl_q, iso_q, en_q, sts_q;
   logic [DATA_W-1:0] set_vec, clr_vec;
   logic              ctl_rst_n;
   logic              wr_ctl, wr_iso, wr_en, wr_sts;

   assign ctl_rst_n = stby_rst_n & main_rst_n;
   assign wr_ctl = wr_i && (addr_i == ADDR_W'(A_CTL));
   assign wr_iso = wr_i && (addr_i == ADDR_W'(A_ISO));
   assign wr_en  = wr_i && (addr_i == ADDR_W'(A_EN));
   assign wr_sts = wr_i && (addr_i == ADDR_W'(A_STS));

   always_comb begin
      set_vec = '0;
      set_vec[B_KB] = kb_act_i;
      set_vec[B_MS] = ms_act_i;
      clr_vec = wr_sts ? (wdata_i & WAKE_MASK) : '0;
   end

   // controller reset: main or standby domain
   always_ff @(posedge clk or negedge ctl_rst_n) begin
      if (!ctl_rst_n)  ctl_q <= '0;
      else if (wr_ctl) ctl_q <= wdata_i & CTL_MASK;
   end

   // standby-domain registers
   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n) begin
         iso_q <= '0;
         en_q  <= '0;
         sts_q <= '0;
      end else begin
         if (wr_iso) iso_q <= wdata_i & ISO_MASK;
         if (wr_en)  en_q  <= wdata_i & WAKE_MASK;
         sts_q <= (sts_q & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(A_CTL)) rdata_o = ctl_q;
      if (addr_i == ADDR_W'(A_ISO)) rdata_o = iso_q;
      if (addr_i == ADDR_W'(A_EN))  rdata_o = en_q;
      if (addr_i == ADDR_W'(A_STS)) rdata_o = sts_q;
   end

   assign iso_o     = iso_q;
   assign en_o      = en_q;
   assign sts_o     = sts_q;
   assign ctl_rst_o = ctl_q[B_CTL_RST];

   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!stby_rst_n)
      (sts_q[B_KB] && !(wr_sts && wdata_i[B_KB])) |=> sts_q[B_KB]); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!stby_rst_n)
      ms_act_i |=> sts_q[B_MS]); // R8
   AST_ISO_KEEP: assert property (@(posedge clk) disable iff (!stby_rst_n)
      (iso_q[B_ISO_MS] && !wr_iso) |=> iso_q[B_ISO_MS]); // R3
   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!ctl_rst_n)
      (ctl_rst_o && !wr_ctl) |=> ctl_rst_o); // R4
endmodule

// File: rtl/ps2_wake_iso.sv
module ps2_wake_iso
   import ps2w_pkg::*;
#(
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int unsigned A_CTL       = 0,
   parameter int unsigned A_ISO       = 1,
   parameter int unsigned A_EN        = 2,
   parameter int unsigned A_STS       = 3,
   parameter int unsigned B_CTL_RST   = 6,
   parameter int unsigned B_ISO_MS    = 6,
   parameter int unsigned B_ISO_KB    = 5,
   parameter int unsigned B_KB        = 3,
   parameter int unsigned B_MS        = 4,
   parameter bit          PME_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              stby_rst_n,
   input  logic              main_rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              kb_clk_i,
   input  logic              kb_dat_i,
   input  logic              ms_clk_i,
   input  logic              ms_dat_i,
   output logic              kbc_kb_clk,
   output logic              kbc_kb_dat,
   output logic              kbc_ms_clk,
   output logic              kbc_ms_dat,
   output logic              kbc_rst,
   output logic              pme_n
);
   if (B_CTL_RST >= DATA_W || B_ISO_MS >= DATA_W || B_ISO_KB >= DATA_W ||
       B_KB >= DATA_W || B_MS >= DATA_W) begin : g_bad_bits
      $error("ps2_wake_iso: bit position outside data width");
   end
   if (B_ISO_MS == B_ISO_KB || B_KB == B_MS) begin : g_bad_overlap
      $error("ps2_wake_iso: device bits must differ");
   end
   if (A_CTL == A_ISO || A_CTL == A_EN || A_CTL == A_STS ||
       A_ISO == A_EN || A_ISO == A_STS || A_EN == A_STS ||
       A_STS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ps2_wake_iso: register addresses must be distinct and in range");
   end

   logic [1:0]        dat_sync;   // [0] keyboard, [1] mouse
   logic [DATA_W-1:0] iso_q, en_q, sts_q;
   logic              wake_any;

   ps2w_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (2),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (stby_rst_n),
      .d_i   ({ms_dat_i, kb_dat_i}),
      .q_o   (dat_sync)
   );

   ps2w_regs #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W),
      .A_CTL (A_CTL), .A_ISO (A_ISO), .A_EN (A_EN), .A_STS (A_STS),
      .B_CTL_RST (B_CTL_RST), .B_ISO_MS (B_ISO_MS), .B_ISO_KB (B_ISO_KB),
      .B_KB (B_KB), .B_MS (B_MS)
   ) u_regs (
      .clk        (clk),
      .stby_rst_n (stby_rst_n),
      .main_rst_n (main_rst_n),
      .wr_i       (reg_wr),
      .addr_i     (reg_addr),
      .wdata_i    (reg_wdata),
      .rdata_o    (reg_rdata),
      .kb_act_i   (~dat_sync[0]),
      .ms_act_i   (~dat_sync[1]),
      .iso_o      (iso_q),
      .en_o       (en_q),
      .sts_o      (sts_q),
      .ctl_rst_o  (kbc_rst)
   );

   ps2w_gate #(.BLOCK_LEVEL(1'b1)) u_gate_kb (
      .clk_i   (kb_clk_i),
      .dat_i   (kb_dat_i),
      .block_i (iso_q[B_ISO_KB]),
      .clk_o   (kbc_kb_clk),
      .dat_o   (kbc_kb_dat)
   );

   ps2w_gate #(.BLOCK_LEVEL(1'b1)) u_gate_ms (
      .clk_i   (ms_clk_i),
      .dat_i   (ms_dat_i),
      .block_i (iso_q[B_ISO_MS]),
      .clk_o   (kbc_ms_clk),
      .dat_o   (kbc_ms_dat)
   );

   assign wake_any = (sts_q[B_KB] & en_q[B_KB]) | (sts_q[B_MS] & en_q[B_MS]);

   if (PME_REG) begin : g_pme_reg
      always_ff @(posedge clk or negedge stby_rst_n) begin
         if (!stby_rst_n) pme_n <= 1'b1;
         else             pme_n <= ~wake_any;
      end
      AST_PME_CAUSE: assert property (@(posedge clk) disable iff (!stby_rst_n)
         $fell(pme_n) |-> $past(wake_any)); // R9
   end else begin : g_pme_comb
      assign pme_n = ~wake_any;
      AST_PME_CAUSE: assert property (@(posedge clk) disable iff (!stby_rst_n)
         !pme_n |-> (|(sts_q & en_q))); // R9
   end

   AST_MS_BLOCKED: assert property (@(posedge clk) disable iff (!stby_rst_n)
      iso_q[B_ISO_MS] |-> (kbc_ms_clk && kbc_ms_dat)); // R1
   AST_KB_BLOCKED: assert property (@(posedge clk) disable iff (!stby_rst_n)
      iso_q[B_ISO_KB] |-> (kbc_kb_clk && kbc_kb_dat)); // R2
endmodule

// File: tb/ps2_wake_iso_tb.sv
`timescale 1ns/1ps
module ps2_wake_iso_tb;
   typedef struct packed {
      logic iso_k, iso_m, en_k, en_m, sts_k, sts_m, ctl;
      logic k1, k2, m1, m2;
   } model_t;

   logic       clk = 1'b0;
   logic       stby_rst_n = 1'b0, main_rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       kb_clk_i = 1'b1, kb_dat_i = 1'b1, ms_clk_i = 1'b1, ms_dat_i = 1'b1;
   logic       kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat, kbc_rst, pme_n;

   int unsigned n_chk = 0, n_fail = 0;
   model_t      m;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   ps2_wake_iso u_dut (
      .clk(clk), .stby_rst_n(stby_rst_n), .main_rst_n(main_rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i), .ms_clk_i(ms_clk_i), .ms_dat_i(ms_dat_i),
      .kbc_kb_clk(kbc_kb_clk), .kbc_kb_dat(kbc_kb_dat), .kbc_ms_clk(kbc_ms_clk),
      .kbc_ms_dat(kbc_ms_dat), .kbc_rst(kbc_rst), .pme_n(pme_n)
   );

   function automatic model_t reset_model(input model_t cur, input logic sr, input logic mr);
      model_t r = cur;
      if (!sr) r = '{iso_k:0, iso_m:0, en_k:0, en_m:0, sts_k:0, sts_m:0, ctl:0,
                     k1:1, k2:1, m1:1, m2:1};
      else if (!mr) r.ctl = 1'b0;
      return r;
   endfunction

   function automatic model_t next_model(input model_t c, input logic wr, input logic [1:0] a,
                                         input logic [7:0] d, input logic kd, input logic md,
                                         input logic sr, input logic mr);
      model_t n = c;
      n.k1 = kd; n.k2 = c.k1; n.m1 = md; n.m2 = c.m1;
      if (wr && a == 2'd0) n.ctl = d[6];
      if (wr && a == 2'd1) begin n.iso_m = d[6]; n.iso_k = d[5]; end
      if (wr && a == 2'd2) begin n.en_k = d[3]; n.en_m = d[4]; end
      if (wr && a == 2'd3) begin
         if (d[3]) n.sts_k = 1'b0;
         if (d[4]) n.sts_m = 1'b0;
      end
      if (!c.k2) n.sts_k = 1'b1;
      if (!c.m2) n.sts_m = 1'b1;
      return reset_model(n, sr, mr);
   endfunction

   function automatic logic [7:0] exp_rd(input model_t c, input logic [1:0] a);
      case (a)
         2'd0:    return {1'b0, c.ctl, 6'b0};
         2'd1:    return {1'b0, c.iso_m, c.iso_k, 5'b0};
         2'd2:    return {3'b0, c.en_m, c.en_k, 3'b0};
         default: return {3'b0, c.sts_m, c.sts_k, 3'b0};
      endcase
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string rd_tag);
      check(reg_rdata, exp_rd(m, reg_addr), rd_tag);
      check({7'b0, kbc_ms_clk}, {7'b0, ms_clk_i | m.iso_m}, "R1 mouse clock");
      check({7'b0, kbc_ms_dat}, {7'b0, ms_dat_i | m.iso_m}, "R1 mouse data");
      check({7'b0, kbc_kb_clk}, {7'b0, kb_clk_i | m.iso_k}, "R2 keyboard clock");
      check({7'b0, kbc_kb_dat}, {7'b0, kb_dat_i | m.iso_k}, "R2 keyboard data");
      check({7'b0, kbc_rst}, {7'b0, m.ctl}, "R4 controller reset");
      check({7'b0, pme_n}, {7'b0, !((m.sts_k & m.en_k) | (m.sts_m & m.en_m))}, "R9 pme_n");
   endtask

   // called at a falling edge: drive inputs, advance one cycle, check at next falling edge
   task automatic cycle(input logic wr, input logic [1:0] a, input logic [7:0] d,
                        input logic kc, input logic kd, input logic mc, input logic md,
                        input logic sr, input logic mr, input string tag);
      model_t nm;
      nm = next_model(m, wr, a, d, kd, md, sr, mr);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      kb_clk_i = kc; kb_dat_i = kd; ms_clk_i = mc; ms_dat_i = md;
      stby_rst_n = sr; main_rst_n = mr;
      @(posedge clk);
      @(negedge clk);
      m = nm;
      check_all(tag);
   endtask

   task automatic rd(input logic [1:0] a, input logic kd, input logic md, input string tag);
      cycle(1'b0, a, 8'h00, 1'b1, kd, 1'b1, md, 1'b1, 1'b1, tag);
   endtask

   task automatic wrt(input logic [1:0] a, input logic [7:0] d, input logic kd,
                      input logic md, input string tag);
      cycle(1'b1, a, d, 1'b1, kd, 1'b1, md, 1'b1, 1'b1, tag);
   endtask

   initial begin
      void'($urandom(32'h5eed_2b17));
      m = reset_model('0, 1'b0, 1'b0);
      @(negedge clk);
      // reset state
      cycle(1'b0, 2'd1, 8'h00, 1, 1, 1, 1, 1'b0, 1'b0, "R3 reset iso");
      cycle(1'b0, 2'd3, 8'h00, 1, 1, 1, 1, 1'b0, 1'b0, "R3 reset status");
      rd(2'd2, 1, 1, "R3 reset enable");
      rd(2'd0, 1, 1, "R4 reset ctl");
      // isolation on both devices, lines toggling
      wrt(2'd1, 8'hFF, 1, 1, "R10 iso unused bits");
      for (int i = 0; i < 4; i++)
         cycle(1'b0, 2'd1, 8'h00, i[0], i[1], ~i[0], ~i[1], 1, 1, "R1 R2 blocked");
      // keyboard low while isolated: status must still set
      for (int i = 0; i < 4; i++) rd(2'd3, 0, 1, "R6 R5 kbd status under isolation");
      // clear while still low: set wins
      wrt(2'd3, 8'h08, 0, 1, "R8 set beats clear");
      rd(2'd3, 1, 1, "R8 status after race");
      for (int i = 0; i < 3; i++) rd(2'd3, 1, 1, "R7 sticky after release");
      wrt(2'd3, 8'h00, 1, 1, "R7 write zero keeps");
      rd(2'd3, 1, 1, "R7 still set");
      wrt(2'd3, 8'h08, 1, 1, "R7 write one clears");
      rd(2'd3, 1, 1, "R7 cleared");
      // mouse wake with enables
      wrt(2'd1, 8'h00, 1, 1, "R1 R2 isolation off");
      wrt(2'd2, 8'h18, 1, 1, "R9 enable both");
      for (int i = 0; i < 4; i++) rd(2'd3, 1, 0, "R5 R9 mouse wake");
      // controller reset held then main reset
      wrt(2'd0, 8'h40, 1, 1, "R4 assert ctl");
      for (int i = 0; i < 3; i++) rd(2'd0, 1, 1, "R4 held");
      wrt(2'd1, 8'h60, 1, 1, "R3 load iso");
      cycle(1'b0, 2'd1, 8'h00, 1, 1, 1, 1, 1'b1, 1'b0, "R3 iso through main reset");
      cycle(1'b0, 2'd2, 8'h00, 1, 1, 1, 1, 1'b1, 1'b0, "R3 enable through main reset");
      rd(2'd3, 1, 1, "R3 status through main reset");
      rd(2'd0, 1, 1, "R4 ctl cleared by main reset");
      wrt(2'd0, 8'h40, 1, 1, "R4 assert again");
      wrt(2'd0, 8'h00, 1, 1, "R4 release");
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic wr, kd, md, sr, mr;
         logic [1:0] a;
         logic [7:0] d;
         wr = ($urandom % 4) == 0;
         a  = 2'($urandom);
         d  = 8'($urandom);
         kd = ($urandom % 8) != 0;
         md = ($urandom % 8) != 0;
         sr = ($urandom % 200) != 0;
         mr = ($urandom % 100) != 0;
         cycle(wr, a, d, 1'($urandom), kd, 1'($urandom), md, sr, mr, "R10 random read");
      end
      cycle(1'b0, 2'd3, 8'h00, 1, 1, 1, 1, 1'b0, 1'b1, "R3 standby clears status");
      rd(2'd1, 1, 1, "R3 standby cleared iso");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20ns * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule